// File: doc/BRIEF.md
# Peer Presence Discovery Table

This block holds a one-bit-per-device map of which peers exist on a shared bus, with one bit for each possible device number. After reset every peer is assumed present. The first packet that has to be flooded then sets off a single sweep. The sweep sends a buffer request to every other device number. Each request that comes back with a no-target abort removes that device from the map. A request/response handshake stands in for the bus master.

A CPU register port can overwrite the map at any time. It can also select manual mode, which stops the sweep from starting, and it can replace the local device number. The local device number is loaded from a strap input while reset is active. Aborts seen on bus traffic other than the sweep also clear the target's bit, through a separate report input.

Top module: `peer_presence_table`

## Requirements
- R1: While reset is active, `presence` becomes all ones and `local_id` loads `strap_id`. After reset, `manual_mode`, `sweep_done` and `req_valid` are 0.
- R2: In automatic mode (`manual_mode`=0), a `flood_pkt` pulse sampled on a clock edge before the sweep has run raises `req_valid` right after that edge. `req_dev` then holds the lowest device number that is not `local_id`.
- R3: The sweep visits device numbers in ascending order and never issues `local_id`. It has one request outstanding at a time. `req_dev` holds steady until `rsp_valid` is sampled.
- R4: A sweep response with `rsp_abort`=1 clears `presence[req_dev]` on that edge. A response with `rsp_abort`=0 leaves the bit set.
- R5: After the response to the last device number, `sweep_done` rises and `req_valid` falls. Later `flood_pkt` pulses start no new sweep until the next reset.
- R6: An `other_abort_valid` pulse clears `presence[other_abort_dev]` at any time, whether or not a sweep is running.
- R7: A write to offset 0x00 sets `manual_mode` from data bit 2. While `manual_mode` is 1, `flood_pkt` does not start the sweep.
- R8: A write to offset 0x20 replaces `presence` with data bits [31:0], in both automatic and manual mode.
- R9: When a table write and an abort clear hit the same edge, the table written takes the value of the write data.
- R10: A write to offset 0x10 loads `local_id` from data bits [26:22]. Its other data bits and the map are unaffected.
- R11: When `local_id` is 31, the sweep ends after device 30, having issued 0 through 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_id | input | 5 | Device number loaded during reset |
| flood_pkt | input | 1 | Pulse: a good packet must be flooded |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | 8 | Register offset: 0x00 control, 0x10 base address, 0x20 table |
| cpu_wdata | input | 32 | CPU write data |
| req_valid | output | 1 | Sweep buffer request outstanding |
| req_dev | output | 5 | Device number of the outstanding request |
| rsp_valid | input | 1 | Response to the outstanding request |
| rsp_abort | input | 1 | Response ended in a no-target abort |
| other_abort_valid | input | 1 | Abort seen on non-sweep traffic |
| other_abort_dev | input | 5 | Target device number of that abort |
| presence | output | 32 | Presence map, 1 = device present |
| local_id | output | 5 | Current local device number |
| manual_mode | output | 1 | Manual mode selected |
| sweep_done | output | 1 | Sweep has completed since reset |

## Verification
All results appear after exactly one clock edge. `req_valid` rises on the edge that samples `flood_pkt`. A map bit falls on the edge that samples an abort response or abort report. `req_dev` advances on that same edge. Register writes take effect on the edge that samples `cpu_wr`. The bench drives every input on a falling edge and reads outputs on the next falling edge. Each result is therefore checked half a period after the single rising edge that produces it. The responder acts only on a falling edge where no response is pending. Because of this, each request has to stay stable for a full idle cycle before it is compared against the scoreboard queue.

// File: rtl/peer_presence_table.sv
module peer_presence_table #(
  parameter int NUM_DEV = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(NUM_DEV)-1:0] strap_id,
  input  logic                       flood_pkt,
  input  logic                       cpu_wr,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [DATA_W-1:0]          cpu_wdata,
  output logic                       req_valid,
  output logic [$clog2(NUM_DEV)-1:0] req_dev,
  input  logic                       rsp_valid,
  input  logic                       rsp_abort,
  input  logic                       other_abort_valid,
  input  logic [$clog2(NUM_DEV)-1:0] other_abort_dev,
  output logic [NUM_DEV-1:0]         presence,
  output logic [$clog2(NUM_DEV)-1:0] local_id,
  output logic                       manual_mode,
  output logic                       sweep_done
);
  localparam int ID_W     = $clog2(NUM_DEV);
  localparam int ID_LSB   = 22;
  localparam int MODE_BIT = 2;
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] BASE_OFS = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] TAB_OFS  = ADDR_W'(8'h20);
  localparam logic [ID_W-1:0]   TOP_ID   = ID_W'(NUM_DEV - 1);

  logic            busy;
  logic [ID_W-1:0] cur, first_dev, last_dev, step, nxt;
  logic [NUM_DEV-1:0] clr;
  logic wr_ctrl, wr_base, wr_tab, start, rsp_take;

  assign wr_ctrl  = cpu_wr && cpu_addr == CTRL_OFS;
  assign wr_base  = cpu_wr && cpu_addr == BASE_OFS;
  assign wr_tab   = cpu_wr && cpu_addr == TAB_OFS;
  assign start    = flood_pkt && !busy && !sweep_done && !manual_mode;
  assign rsp_take = busy && rsp_valid;

  assign first_dev = (local_id == '0) ? ID_W'(1) : '0;
  assign last_dev  = (local_id == TOP_ID) ? TOP_ID - ID_W'(1) : TOP_ID;
  assign step      = cur + ID_W'(1);
  assign nxt       = (step == local_id) ? step + ID_W'(1) : step;

  assign req_valid = busy;
  assign req_dev   = cur;

  always_comb begin
    clr = '0;
    if (rsp_take && rsp_abort) clr[cur] = 1'b1;
    if (other_abort_valid)     clr[other_abort_dev] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presence    <= '1;
      local_id    <= strap_id;
      manual_mode <= 1'b0;
      sweep_done  <= 1'b0;
      busy        <= 1'b0;
      cur         <= '0;
    end else begin
      presence <= wr_tab ? cpu_wdata[NUM_DEV-1:0] : presence & ~clr;
      if (wr_ctrl) manual_mode <= cpu_wdata[MODE_BIT];
      if (wr_base) local_id <= cpu_wdata[ID_LSB +: ID_W];
      if (start) begin
        busy <= 1'b1;
        cur  <= first_dev;
      end else if (rsp_take) begin
        if (cur == last_dev) begin
          busy       <= 1'b0;
          sweep_done <= 1'b1;
        end else begin
          cur <= nxt;
        end
      end
    end
  end
endmodule

module peer_presence_checks #(
  parameter int NUM_DEV = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cpu_wr,
  input logic [ADDR_W-1:0]          cpu_addr,
  input logic [DATA_W-1:0]          cpu_wdata,
  input logic                       req_valid,
  input logic [$clog2(NUM_DEV)-1:0] req_dev,
  input logic                       rsp_valid,
  input logic                       rsp_abort,
  input logic [NUM_DEV-1:0]         presence,
  input logic [$clog2(NUM_DEV)-1:0] local_id,
  input logic                       manual_mode,
  input logic                       sweep_done
);
  logic tab_wr;
  assign tab_wr = cpu_wr && cpu_addr == ADDR_W'(8'h20);

  p_reset_all_r1: assert property (@(posedge clk)
    !rst_n |=> presence == '1 && !req_valid && !sweep_done);

  p_req_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !rsp_valid |=> req_valid && $stable(req_dev));

  p_skip_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_dev != local_id);

  p_abort_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && rsp_valid && rsp_abort && !tab_wr |=> !presence[$past(req_dev)]);

  p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> !req_valid);

  p_manual_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    manual_mode && !req_valid |=> !req_valid);

  p_cpu_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tab_wr |=> presence == $past(cpu_wdata[NUM_DEV-1:0]));
endmodule

bind peer_presence_table peer_presence_checks #(
  .NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .req_valid(req_valid), .req_dev(req_dev),
  .rsp_valid(rsp_valid), .rsp_abort(rsp_abort), .presence(presence),
  .local_id(local_id), .manual_mode(manual_mode), .sweep_done(sweep_done)
);

// File: tb/sim_peer_presence_table.sv
`timescale 1ns/1ps
module sim_peer_presence_table;
  logic clk = 0, rst_n = 0;
  logic [4:0] strap_id = 5'd5;
  logic flood_pkt = 0, cpu_wr = 0;
  logic [7:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic req_valid;
  logic [4:0] req_dev;
  logic rsp_valid = 0, rsp_abort = 0;
  logic other_abort_valid = 0;
  logic [4:0] other_abort_dev = '0;
  logic [31:0] presence;
  logic [4:0] local_id;
  logic manual_mode, sweep_done;

  int errors = 0, checks = 0;
  int exp_q[$];
  logic [31:0] abort_mask = '0;
  logic [31:0] exp_tab;

  always #2 clk = ~clk;

  peer_presence_table u0 (
    .clk(clk), .rst_n(rst_n), .strap_id(strap_id), .flood_pkt(flood_pkt),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .req_valid(req_valid), .req_dev(req_dev), .rsp_valid(rsp_valid),
    .rsp_abort(rsp_abort), .other_abort_valid(other_abort_valid),
    .other_abort_dev(other_abort_dev), .presence(presence), .local_id(local_id),
    .manual_mode(manual_mode), .sweep_done(sweep_done));

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // scoreboard monitor: pops expected request numbers and answers each request
  always @(negedge clk) begin
    if (!rst_n) rsp_valid <= 0;
    else if (rsp_valid) rsp_valid <= 0;
    else if (req_valid) begin
      if (exp_q.size() == 0) check(0, "R3 unexpected request", 32'(req_dev), 32'hFFFF_FFFF);
      else begin
        int e;
        e = exp_q.pop_front();
        check(req_dev == 5'(e), "R3 request order", 32'(req_dev), 32'(e));
      end
      rsp_valid <= 1;
      rsp_abort <= abort_mask[req_dev];
    end
  end

  task automatic push_sweep(input int loc);
    for (int d = 0; d < 32; d++) if (d != loc) exp_q.push_back(d);
  endtask

  task automatic do_reset(input logic [4:0] s);
    @(negedge clk); rst_n = 0; strap_id = s;
    exp_q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic cpu_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic pulse_flood();
    @(negedge clk); flood_pkt = 1;
    @(negedge clk); flood_pkt = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!sweep_done && n < 400) begin @(negedge clk); n++; end
    check(sweep_done, "R5 sweep completes", 32'(sweep_done), 1);
  endtask

  initial begin
    #(4 * 150000);
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset(5'd5);
    @(negedge clk);
    check(presence == '1, "R1 table all ones", presence, 32'hFFFF_FFFF);
    check(local_id == 5'd5, "R1 strap id", 32'(local_id), 5);
    check(!manual_mode && !sweep_done && !req_valid, "R1 flags clear",
          {29'd0, manual_mode, sweep_done, req_valid}, 0);

    // R6: non-sweep abort before sweep
    @(negedge clk); other_abort_valid = 1; other_abort_dev = 5'd7;
    @(negedge clk); other_abort_valid = 0;
    exp_tab = 32'hFFFF_FF7F;
    check(presence == exp_tab, "R6 other abort clears", presence, exp_tab);

    // R2-R5 sweep with local 5
    abort_mask = 32'h8C00_0A26;
    push_sweep(5);
    @(negedge clk); flood_pkt = 1;
    @(negedge clk); flood_pkt = 0;
    check(req_valid, "R2 request after flood", 32'(req_valid), 1);
    wait_done();
    exp_tab = exp_tab & ~(abort_mask & ~(32'd1 << 5));
    check(presence == exp_tab, "R4 aborted bits cleared", presence, exp_tab);
    check(exp_q.size() == 0, "R3 all numbers visited", exp_q.size(), 0);
    check(!req_valid, "R5 request drops", 32'(req_valid), 0);
    pulse_flood();
    repeat (3) @(negedge clk);
    check(!req_valid && exp_q.size() == 0, "R5 no second sweep", 32'(req_valid), 0);

    // R8 / R9 table writes
    cpu_write(8'h20, 32'h1234_5678);
    check(presence == 32'h1234_5678, "R8 table write", presence, 32'h1234_5678);
    @(negedge clk); cpu_wr = 1; cpu_addr = 8'h20; cpu_wdata = 32'hFFFF_FFFF;
    other_abort_valid = 1; other_abort_dev = 5'd3;
    @(negedge clk); cpu_wr = 0; other_abort_valid = 0;
    check(presence == 32'hFFFF_FFFF, "R9 cpu write wins", presence, 32'hFFFF_FFFF);

    // R10 base address write
    cpu_write(8'h10, (32'd19 << 22) | 32'hF83F_FFFF);
    check(local_id == 5'd19, "R10 local id from [26:22]", 32'(local_id), 19);
    check(presence == 32'hFFFF_FFFF, "R10 table untouched", presence, 32'hFFFF_FFFF);

    // R7 manual mode
    do_reset(5'd9);
    cpu_write(8'h00, 32'h0000_0004);
    check(manual_mode, "R7 manual selected", 32'(manual_mode), 1);
    pulse_flood();
    repeat (3) @(negedge clk);
    check(!req_valid && !sweep_done, "R7 no sweep in manual", 32'(req_valid), 0);
    cpu_write(8'h20, 32'h0000_0202);
    check(presence == 32'h0000_0202, "R8 table write in manual", presence, 32'h0000_0202);

    // R11 local id 31
    do_reset(5'd31);
    abort_mask = 32'h8000_0001;
    push_sweep(31);
    pulse_flood();
    wait_done();
    check(exp_q.size() == 0, "R11 sweep ends at 30", exp_q.size(), 0);
    check(presence == 32'hFFFF_FFFE, "R11 table", presence, 32'hFFFF_FFFE);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule